// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives one output clock from the clock that runs it. Two register fields set the lengths of the output's high and low phases separately, each in parent cycles, so the output can have an uneven duty cycle. A divide-enable bit picks between divided operation and a bypass in which the parent clock goes straight through. A second register holds a clock-enable bit that starts and stops the output without cutting a pulse short.

Software writes a divider word and a gate word over a small single-cycle register port and can read both back. A new divider setting waits for the end of the output period in progress, so periods never mix two settings. A build parameter can drop the gate register. That channel then runs whenever the parent clock runs.

Top module: `gated_clk_div`

## Requirements
- R1: After reset both registers read zero, the divider is in bypass and the output is held low because the gate is off.
- R2: With the divide-enable bit (bit 31 of the divider word) clear and the gate on, the output is high while the parent clock is high and low while it is low.
- R3: With the divide-enable bit set, the output is high for (high field + 1) parent cycles and low for (low field + 1) parent cycles, where the high field is bits 7:0 and the low field is bits 15:8 of the divider word (word index 0).
- R4: With both fields zero the output divides by two, one parent cycle high and one low, and an uneven setting such as high 5, low 0 gives six cycles high and one low.
- R5: A divider word written during an output period takes effect only after that period's low phase ends, so the current period completes with the old phase lengths.
- R6: Clearing the gate bit (bit 0 of the gate word, word index 1) lets a high phase in progress finish at its full length, after which the output stays low.
- R7: Setting the gate bit again restarts the output with complete phases of the programmed lengths.
- R8: Reads return the last value written to each field, and every bit outside the fields reads as zero.
- R9: A channel built without a gate runs whenever the parent clock runs, reads its gate bit as one, and ignores writes to the gate word.
- R10: Clearing the divide-enable bit returns the output to bypass once the current divided period has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low reset, sampled on the rising parent edge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word index: 0 divider, 1 gate |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the word at reg_addr_i, combinational |
| clk_o | output | 1 | Divided or bypassed output clock |

## Verification
The assertions take for granted that register writes arrive synchronously to the parent clock and that reset is held for at least two parent edges, so that the phase counter, the applied settings and the gate flop start from known values. The stimulus drives every register access away from the rising edge and holds reset for three cycles. Divided-mode checks sample the output just after each rising edge, where it comes only from flops. The bypass checks sample it in the middle of each parent half-period, where the bypass path is settled.

// File: rtl/gated_clk_div_pkg.sv
// Package: shared word indices and phase type for the clock divider.
// Assumes the register port addresses whole words.
package gated_clk_div_pkg;

    localparam int DIV_WORD  = 0;
    localparam int GATE_WORD = 1;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/gated_clk_div_regs.sv
// Module: register file holding the divider word and the gate word.
// Only field bits are stored and all other bits read as zero. When HAS_GATE
// is 0 the gate is a constant one and gate writes are dropped.
module gated_clk_div_regs #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int EN_POS   = 31,
    parameter int HI_POS   = 0,
    parameter int HI_W     = 8,
    parameter int LO_POS   = 8,
    parameter int LO_W     = 8,
    parameter int GATE_POS = 0,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              prog_en_o,
    output logic [HI_W-1:0]   prog_hi_o,
    output logic [LO_W-1:0]   prog_lo_o,
    output logic              gate_en_o
);
    import gated_clk_div_pkg::*;

    localparam logic [ADDR_W-1:0] DIV_A  = ADDR_W'(DIV_WORD);
    localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(GATE_WORD);

    logic div_hit;
    logic gate_hit;
    logic unused_wdata;

    assign div_hit      = wr_i && (addr_i == DIV_A);
    assign gate_hit     = wr_i && (addr_i == GATE_A);
    assign unused_wdata = ^wdata_i;

    // Divider word storage: enable plus the two phase fields.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prog_en_o <= 1'b0;
            prog_hi_o <= '0;
            prog_lo_o <= '0;
        end else if (div_hit) begin
            prog_en_o <= wdata_i[EN_POS];
            prog_hi_o <= wdata_i[HI_POS +: HI_W];
            prog_lo_o <= wdata_i[LO_POS +: LO_W];
        end
    end

    generate
        if (HAS_GATE) begin : g_gate
            // Gate word storage: one enable bit.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    gate_en_o <= 1'b0;
                end else if (gate_hit) begin
                    gate_en_o <= wdata_i[GATE_POS];
                end
            end
        end else begin : g_nogate
            logic unused_gate_hit;
            assign unused_gate_hit = gate_hit;
            assign gate_en_o       = 1'b1;
        end
    endgenerate

    // Read mux: place the stored fields in a zeroed word.
    always_comb begin
        rdata_o = '0;
        if (addr_i == DIV_A) begin
            rdata_o[EN_POS]            = prog_en_o;
            rdata_o[HI_POS +: HI_W]    = prog_hi_o;
            rdata_o[LO_POS +: LO_W]    = prog_lo_o;
        end else if (addr_i == GATE_A) begin
            rdata_o[GATE_POS]          = gate_en_o;
        end
    end

endmodule

// File: rtl/gated_clk_div_phase.sv
// Module: phase sequencer. It counts parent cycles through a high phase and a
// low phase and copies the programmed settings only at a period boundary.
// In bypass every cycle counts as a boundary, so a new setting is taken on
// the next edge.
module gated_clk_div_phase #(
    parameter int HI_W = 8,
    parameter int LO_W = 8,
    parameter int CW   = (HI_W > LO_W) ? HI_W : LO_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            prog_en_i,
    input  logic [HI_W-1:0] prog_hi_i,
    input  logic [LO_W-1:0] prog_lo_i,
    output logic            act_en_o,
    output logic [HI_W-1:0] act_hi_o,
    output logic [LO_W-1:0] act_lo_o,
    output logic            phase_hi_o,
    output logic [CW-1:0]   cnt_o
);
    import gated_clk_div_pkg::*;

    phase_e phase_q;
    logic   hi_done;
    logic   wrap;

    assign hi_done    = (phase_q == PH_HIGH) && (cnt_o == CW'(act_hi_o));
    assign wrap       = !act_en_o || ((phase_q == PH_LOW) && (cnt_o == CW'(act_lo_o)));
    assign phase_hi_o = (phase_q == PH_HIGH);

    // Phase counter with settings applied at the period boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_en_o <= 1'b0;
            act_hi_o <= '0;
            act_lo_o <= '0;
            phase_q  <= PH_HIGH;
            cnt_o    <= '0;
        end else if (wrap) begin
            act_en_o <= prog_en_i;
            act_hi_o <= prog_hi_i;
            act_lo_o <= prog_lo_i;
            phase_q  <= PH_HIGH;
            cnt_o    <= '0;
        end else if (hi_done) begin
            phase_q  <= PH_LOW;
            cnt_o    <= '0;
        end else begin
            cnt_o    <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/gated_clk_div_gate.sv
// Module: glitch-free gating and output selection. In divided mode the gate
// flop changes only while the divided output is low. In bypass a flop on the
// falling edge changes the gate only while the parent clock is low.
module gated_clk_div_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gate_en_i,
    input  logic act_en_i,
    input  logic phase_hi_i,
    output logic run_q_o,
    output logic clk_o
);
    logic byp_q;

    // Divided-path gate: follows the gate bit only during the low phase.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q_o <= 1'b0;
        end else if (!phase_hi_i || !act_en_i) begin
            run_q_o <= gate_en_i;
        end
    end

    // Bypass gate: follows the gate bit on the falling parent edge.
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            byp_q <= 1'b0;
        end else begin
            byp_q <= gate_en_i;
        end
    end

    // Output select: divided phase or gated parent clock.
    always_comb begin
        clk_o = act_en_i ? (phase_hi_i & run_q_o) : (clk_i & byp_q);
    end

endmodule

// File: rtl/gated_clk_div.sv
// Module: top of the gated programmable clock divider. It joins the register
// file, the phase sequencer and the output gate. Register accesses are
// assumed synchronous to clk_i.
module gated_clk_div #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int EN_POS   = 31,
    parameter int HI_POS   = 0,
    parameter int HI_W     = 8,
    parameter int LO_POS   = 8,
    parameter int LO_W     = 8,
    parameter int GATE_POS = 0,
    parameter bit HAS_GATE = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              clk_o
);
    localparam int CW = (HI_W > LO_W) ? HI_W : LO_W;

    logic            prog_en;
    logic [HI_W-1:0] prog_hi;
    logic [LO_W-1:0] prog_lo;
    logic            gate_en;
    logic            act_en;
    logic [HI_W-1:0] act_hi;
    logic [LO_W-1:0] act_lo;
    logic            phase_hi;
    logic [CW-1:0]   cnt;
    logic            run_q;

    gated_clk_div_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_POS(EN_POS),
        .HI_POS(HI_POS), .HI_W(HI_W), .LO_POS(LO_POS), .LO_W(LO_W),
        .GATE_POS(GATE_POS), .HAS_GATE(HAS_GATE)
    ) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .prog_en_o(prog_en),
        .prog_hi_o(prog_hi), .prog_lo_o(prog_lo), .gate_en_o(gate_en)
    );

    gated_clk_div_phase #(.HI_W(HI_W), .LO_W(LO_W), .CW(CW)) phase_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .prog_en_i(prog_en),
        .prog_hi_i(prog_hi), .prog_lo_i(prog_lo), .act_en_o(act_en),
        .act_hi_o(act_hi), .act_lo_o(act_lo), .phase_hi_o(phase_hi),
        .cnt_o(cnt)
    );

    gated_clk_div_gate gate_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .gate_en_i(gate_en),
        .act_en_i(act_en), .phase_hi_i(phase_hi), .run_q_o(run_q),
        .clk_o(clk_o)
    );

endmodule

// File: rtl/gated_clk_div_chk.sv
// Module: assertion checker for gated_clk_div, bound to every instance.
// Assumes reset is held for at least two rising edges.
module gated_clk_div_chk #(
    parameter int HI_W = 8,
    parameter int LO_W = 8,
    parameter int CW   = (HI_W > LO_W) ? HI_W : LO_W
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            act_en,
    input logic [HI_W-1:0] act_hi,
    input logic [LO_W-1:0] act_lo,
    input logic            phase_hi,
    input logic [CW-1:0]   cnt,
    input logic            run_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> (!act_en && phase_hi && cnt == '0 && !run_q));

    // R3
    high_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_en && phase_hi) |-> (cnt <= CW'(act_hi)));

    // R3
    low_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_en && !phase_hi) |-> (cnt <= CW'(act_lo)));

    // R5
    apply_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(act_hi) || !$stable(act_lo) || !$stable(act_en)) |->
            ($past(!act_en) || ($past(!phase_hi) && $past(cnt) == CW'($past(act_lo)))));

    // R6
    gate_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(run_q) |-> ($past(!phase_hi) || $past(!act_en)));

endmodule

bind gated_clk_div gated_clk_div_chk #(.HI_W(HI_W), .LO_W(LO_W)) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_en(act_en), .act_hi(act_hi),
    .act_lo(act_lo), .phase_hi(phase_hi), .cnt(cnt), .run_q(run_q)
);

// File: tb/gated_clk_div_tb_top.sv
`timescale 1ns/1ps
module gated_clk_div_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        clk_o;
    logic        wr2 = 1'b0;
    logic [1:0]  addr2 = '0;
    logic [31:0] wdata2 = '0;
    logic [31:0] rdata2;
    logic        clk_o2;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    gated_clk_div dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .clk_o(clk_o)
    );

    gated_clk_div #(.HAS_GATE(1'b0)) nogate_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr2), .reg_addr_i(addr2),
        .reg_wdata_i(wdata2), .reg_rdata_o(rdata2), .clk_o(clk_o2)
    );

    function automatic logic [31:0] dword(input logic en, input int h, input int l);
        return {en, 15'd0, 8'(l), 8'(h)};
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic sample(output logic v);
        @(posedge clk);
        #1 v = clk_o;
    endtask

    task automatic sync_rise(input string req);
        logic prev = 1'b1;
        logic cur;
        for (int i = 0; i < 2000; i++) begin
            sample(cur);
            if (!prev && cur) return;
            prev = cur;
        end
        check(1'b0, req, 0, 1);
    endtask

    task automatic count_run(input logic v, input int start, output int n);
        logic s;
        n = start;
        for (int i = 0; i < 1000; i++) begin
            sample(s);
            if (s != v) return;
            n++;
        end
    endtask

    task automatic check_bypass(input logic exp_hi, input string req);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1 check(clk_o == exp_hi, req, clk_o, exp_hi);
            @(negedge clk); #1 check(clk_o == 1'b0, req, clk_o, 0);
        end
    endtask

    task automatic measure(input int h, input int l, input string req);
        int nh, nl;
        sync_rise(req);
        for (int p = 0; p < 2; p++) begin
            count_run(1'b1, 1, nh);
            count_run(1'b0, 1, nl);
            check(nh == h + 1, req, nh, h + 1);
            check(nl == l + 1, req, nl, l + 1);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd_reg(2'd0, d); check(d == 0, "R1", d, 0);
        rd_reg(2'd1, d); check(d == 0, "R1", d, 0);
        check_bypass(1'b0, "R1");
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd_reg(2'd1, d); check(d == 32'h1, "R8", d, 32'h1);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, d); check(d == 32'h8000_FFFF, "R8", d, 32'h8000_FFFF);
        wr_reg(2'd0, dword(1'b0, 3, 7));
        rd_reg(2'd0, d); check(d == 32'h0000_0703, "R8", d, 32'h0000_0703);
        rd_reg(2'd2, d); check(d == 0, "R8", d, 0);
        repeat (600) @(posedge clk);
    endtask

    task automatic t_bypass;
        check_bypass(1'b1, "R2");
    endtask

    task automatic t_divide;
        wr_reg(2'd0, dword(1'b1, 2, 4)); measure(2, 4, "R3");
        wr_reg(2'd0, dword(1'b1, 0, 0)); measure(0, 0, "R4");
        wr_reg(2'd0, dword(1'b1, 5, 0)); measure(5, 0, "R4");
    endtask

    task automatic t_period_end;
        int nh, nl;
        logic s;
        wr_reg(2'd0, dword(1'b1, 3, 3));
        measure(3, 3, "R5");
        sync_rise("R5");
        wr = 1'b1; addr = 2'd0; wdata = dword(1'b1, 0, 0);
        sample(s);
        wr = 1'b0;
        check(s == 1'b1, "R5", s, 1);
        count_run(1'b1, 2, nh);
        count_run(1'b0, 1, nl);
        check(nh == 4, "R5", nh, 4);
        check(nl == 4, "R5", nl, 4);
        count_run(1'b1, 1, nh);
        count_run(1'b0, 1, nl);
        check(nh == 1, "R5", nh, 1);
        check(nl == 1, "R5", nl, 1);
    endtask

    task automatic t_gate;
        int nh, nz;
        logic s;
        wr_reg(2'd0, dword(1'b1, 3, 2));
        measure(3, 2, "R6");
        sync_rise("R6");
        wr = 1'b1; addr = 2'd1; wdata = 32'h0;
        sample(s);
        wr = 1'b0;
        check(s == 1'b1, "R6", s, 1);
        count_run(1'b1, 2, nh);
        check(nh == 4, "R6", nh, 4);
        nz = 0;
        for (int i = 0; i < 30; i++) begin
            sample(s);
            if (s) nz++;
        end
        check(nz == 0, "R6", nz, 0);
        wr_reg(2'd1, 32'h1);
        measure(3, 2, "R7");
    endtask

    task automatic t_disable;
        wr_reg(2'd0, dword(1'b0, 3, 2));
        repeat (20) @(posedge clk);
        check_bypass(1'b1, "R10");
    endtask

    task automatic t_nogate;
        logic [31:0] d;
        @(negedge clk); addr2 = 2'd1;
        #1 d = rdata2; check(d == 32'h1, "R9", d, 1);
        @(negedge clk); wr2 = 1'b1; wdata2 = 32'h0;
        @(negedge clk); wr2 = 1'b0;
        #1 d = rdata2; check(d == 32'h1, "R9", d, 1);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1 check(clk_o2 == 1'b1, "R9", clk_o2, 1);
            @(negedge clk); #1 check(clk_o2 == 1'b0, "R9", clk_o2, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        t_nogate;
        t_readback;
        t_bypass;
        t_divide;
        t_period_end;
        t_gate;
        t_disable;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule